// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an 8-bit general-purpose I/O port behind a simple memory-mapped register interface. Its data register appears at every word offset of a 1 KiB window. The word offset inside that window is the bit mask for the access, so software can read or change any subset of pins in a single access and never needs a read-modify-write sequence.

A direction register at offset 0x400 selects, pin by pin, whether the port drives the pin or observes it. For an input pin, a data read returns the pin level after a two-flop synchroniser. For an output pin, a data read returns the stored output latch.

A data write updates the output latch for every selected bit, whatever the direction. A latch bit reaches its pin only while that pin is set as an output.

Top module: `masked_gpio_port`

## Requirements
- R1: While reset is held, and on the first clock after it, the output latch, the direction register, `pin_oe`, `pin_out` and `bus_rdata` are all zero.
- R2: A write to the data window (offset bits [10] = 0) loads latch bit i from `bus_wdata[i]` where address bit i+2 is 1. It leaves latch bit i unchanged where address bit i+2 is 0.
- R3: A read of the data window returns 0 in every bit i whose address bit i+2 is 0.
- R4: The direction register sits at offset 0x400; it is written whole and reads back whole. It resets to 0 (all inputs), and `pin_oe[i]` equals direction bit i, where 1 means output.
- R5: For an input pin, a masked data read returns the pin level through a two-flop synchroniser. Take a pin that changes just before clock edge e1. A read strobed at e1 or at e2 returns the old level, and a read strobed at e3 returns the new level.
- R6: For an output pin, a masked data read returns the output latch bit, whatever the level at the pin.
- R7: A data write updates the latch bits of input pins as well. `pin_out[i]` shows latch bit i while direction bit i is 1, and it is 0 otherwise.
- R8: Address bits [1:0] have no effect on reads or writes.
- R9: Offsets 0x404 to 0x7FF read as zero, and writes to them change neither the latch nor the direction register.
- R10: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read. A write takes effect at the edge where its strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 11 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Pin output enables |

## Verification
Random masks, write data, direction values and pin levels run against a model of the port. A mixed direction register shows whether each read bit comes from the latch or from the synchronised pin. Random masks with the two low address bits set separate masked bits from held bits and cleared bits. Directed cases cover the empty mask and the full mask. They also walk the synchroniser edge by edge to pin its exact latency, and write to offsets beyond the direction register to show that those writes are dropped.

// File: rtl/mgpio_pkg.sv
// Shared types for the masked GPIO port.
package mgpio_pkg;
    // Register region that an access offset decodes to.
    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_DATA = 2'd1,
        REG_DIR  = 2'd2
    } region_e;
endpackage

// File: rtl/mgpio_sync.sv
// Multi-stage input synchroniser, one chain per pin.
// Assumes pin_in is asynchronous; the output is pin_in delayed STAGES clocks.
module mgpio_sync #(
    parameter int unsigned PORT_W = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_sync
);
    logic [PORT_W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= pin_in;
            end
        end else begin : g_next
            // Later stages shift the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/mgpio_regs.sv
// Output latch and direction register with address-mask write semantics.
// Assumes region/mask are decoded by the parent in the strobe cycle.
module mgpio_regs
    import mgpio_pkg::*;
#(
    parameter int unsigned PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  region_e           region,
    input  logic [PORT_W-1:0] mask,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] latch_q,
    output logic [PORT_W-1:0] dir_q
);
    // Update only masked latch bits on a data-window write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (wr_en && region == REG_DATA)
            latch_q <= (latch_q & ~mask) | (wdata & mask);
    end

    // Load the whole direction register on a direction write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= '0;
        else if (wr_en && region == REG_DIR)
            dir_q <= wdata;
    end

    assert_masked_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && region == REG_DATA) |=> ((latch_q & $past(mask)) == ($past(wdata) & $past(mask))));
    assert_unmasked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && region == REG_DATA) |=> (((latch_q ^ $past(latch_q)) & ~$past(mask)) == '0));
    assert_dir_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && region == REG_DIR) |=> (dir_q == $past(wdata)));
    assert_outside_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && region == REG_NONE) |=> ($stable(latch_q) && $stable(dir_q)));
endmodule

// File: rtl/mgpio_rdmux.sv
// Registered read path: selects latch or synchronised pin per bit, then masks.
// Assumes rd_en is a single-cycle strobe; data holds until the next read.
module mgpio_rdmux
    import mgpio_pkg::*;
#(
    parameter int unsigned PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  region_e           region,
    input  logic [PORT_W-1:0] mask,
    input  logic [PORT_W-1:0] latch_q,
    input  logic [PORT_W-1:0] dir_q,
    input  logic [PORT_W-1:0] pin_sync,
    output logic [PORT_W-1:0] rdata
);
    logic [PORT_W-1:0] port_view;
    logic [PORT_W-1:0] rd_next;

    // Per-bit source: outputs report the latch, inputs report the pin.
    always_comb begin
        port_view = (dir_q & latch_q) | (~dir_q & pin_sync);
        unique case (region)
            REG_DATA: rd_next = port_view & mask;
            REG_DIR:  rd_next = dir_q;
            default:  rd_next = '0;
        endcase
    end

    // Capture read data on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_next;
    end

    assert_read_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && region == REG_DATA) |=> ((rdata & ~$past(mask)) == '0));
    assert_read_outside_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && region == REG_NONE) |=> (rdata == '0));
    assert_read_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !rd_en) |=> $stable(rdata));
endmodule

// File: rtl/masked_gpio_port.sv
// Top of the masked GPIO port: address decode, registers, synchroniser, read path.
// Assumes byte-wide accesses; address bits [1:0] are not decoded.
module masked_gpio_port
    import mgpio_pkg::*;
#(
    parameter int unsigned PORT_W   = 8,
    parameter int unsigned ADDR_W   = 11,
    parameter int unsigned SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);
    localparam int unsigned MASK_LSB = 2;
    localparam int unsigned WIN_LSB  = MASK_LSB + PORT_W;
    localparam int unsigned PAGE_W   = ADDR_W - WIN_LSB;

    logic [PORT_W-1:0] mask;
    logic [PAGE_W-1:0] page;
    region_e           region;
    logic [PORT_W-1:0] latch_q;
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] pin_sync;

    assign mask = bus_addr[WIN_LSB-1:MASK_LSB];
    assign page = bus_addr[ADDR_W-1:WIN_LSB];

    // Decode the access offset into a register region.
    always_comb begin
        if (page == PAGE_W'(0))
            region = REG_DATA;
        else if (page == PAGE_W'(1) && mask == '0)
            region = REG_DIR;
        else
            region = REG_NONE;
    end

    mgpio_sync #(.PORT_W(PORT_W), .STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_sync(pin_sync)
    );

    mgpio_regs #(.PORT_W(PORT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .region(region),
        .mask(mask), .wdata(bus_wdata), .latch_q(latch_q), .dir_q(dir_q)
    );

    mgpio_rdmux #(.PORT_W(PORT_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(bus_rd), .region(region), .mask(mask),
        .latch_q(latch_q), .dir_q(dir_q), .pin_sync(pin_sync), .rdata(bus_rdata)
    );

    assign pin_oe  = dir_q;
    assign pin_out = latch_q & dir_q;

    assert_no_drive_on_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);
endmodule

// File: tb/sim_masked_gpio_port.sv
module sim_masked_gpio_port;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [10:0] bus_addr;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_wdata, bus_rdata, pin_in, pin_out, pin_oe;

    int checks = 0;
    int fails  = 0;
    logic [7:0] m_latch, m_dir, m_pin;

    always #10 clk = ~clk;

    masked_gpio_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [7:0] exp_read(input logic [7:0] msk);
        return msk & ((m_dir & m_latch) | (~m_dir & m_pin));
    endfunction

    function automatic logic [10:0] data_addr(input logic [7:0] msk, input logic [1:0] lo);
        return {1'b0, msk, lo};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [10:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_pins(input logic [7:0] p);
        @(negedge clk);
        pin_in = p; m_pin = p;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_pins(input string req);
        check({req, " pin_oe"}, pin_oe, m_dir);
        check({req, " pin_out"}, pin_out, m_latch & m_dir);
    endtask

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog expired actual=00 expected=01");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        void'($urandom(32'h1F0A_2C35));
        rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0; pin_in = '0;
        m_latch = '0; m_dir = '0; m_pin = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rdata", bus_rdata, 8'h00);
        check_pins("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata after release", bus_rdata, 8'h00);
        bus_read(11'h400, rd); check("R1 dir reset", rd, 8'h00);

        // R4 direction write and readback
        bus_write(11'h400, 8'hF0); m_dir = 8'hF0;
        bus_read(11'h400, rd); check("R4 dir readback", rd, 8'hF0);
        check_pins("R4");

        // R2/R7 full-mask write, then empty mask leaves latch unchanged
        bus_write(data_addr(8'hFF, 2'b00), 8'hA5); m_latch = 8'hA5;
        check_pins("R7 full mask");
        bus_write(data_addr(8'h00, 2'b00), 8'h5A);
        check_pins("R2 empty mask");
        bus_write(11'h400, 8'hFF); m_dir = 8'hFF;
        bus_read(data_addr(8'hFF, 2'b00), rd); check("R2 latch after empty mask", rd, 8'hA5);

        // R3 empty-mask read returns zero
        bus_read(data_addr(8'h00, 2'b00), rd); check("R3 empty read", rd, 8'h00);

        // R6 outputs ignore pin levels
        set_pins(8'h0F);
        bus_read(data_addr(8'hFF, 2'b11), rd); check("R6 output read", rd, 8'hA5);

        // R7 latch written while pins are inputs, shown when switched to output
        bus_write(11'h400, 8'h00); m_dir = 8'h00;
        bus_write(data_addr(8'h3C, 2'b00), 8'hFF); m_latch = (m_latch & ~8'h3C) | 8'h3C;
        check_pins("R7 input latch write");
        bus_write(11'h400, 8'h3C); m_dir = 8'h3C;
        check_pins("R7 enable drive");

        // R8 low address bits ignored on write
        bus_write({1'b0, 8'h01, 2'b10}, 8'h00); m_latch[0] = 1'b0;
        bus_write(11'h400, 8'hFF); m_dir = 8'hFF;
        bus_read(data_addr(8'hFF, 2'b01), rd); check("R8 low bits", rd, m_latch);

        // R9 outside region: reads zero, writes discarded
        bus_write(11'h404, 8'h00);
        bus_write(11'h7FC, 8'h00);
        bus_read(11'h404, rd); check("R9 read 0x404", rd, 8'h00);
        bus_read(11'h400, rd); check("R9 dir intact", rd, 8'hFF);
        check_pins("R9");

        // R5 synchroniser latency, edge by edge
        bus_write(11'h400, 8'h00); m_dir = 8'h00;
        set_pins(8'h00);
        @(negedge clk);
        pin_in = 8'hC3; bus_addr = data_addr(8'hFF, 2'b00); bus_rd = 1'b1;
        @(negedge clk); check("R5 strobe e1 old", bus_rdata, 8'h00);
        @(negedge clk); check("R5 strobe e2 old", bus_rdata, 8'h00);
        @(negedge clk); check("R5 strobe e3 new", bus_rdata, 8'hC3);
        bus_rd = 1'b0; m_pin = 8'hC3;
        // R10 data holds with no strobe
        repeat (2) @(negedge clk); check("R10 hold", bus_rdata, 8'hC3);

        // Random mix, checked against the model
        for (int i = 0; i < 400; i++) begin
            logic [7:0] msk, d;
            logic [1:0] lo;
            msk = 8'($urandom); d = 8'($urandom); lo = 2'($urandom);
            case ($urandom % 6)
                0: begin bus_write(data_addr(msk, lo), d);
                         m_latch = (m_latch & ~msk) | (d & msk); check_pins("R2 random write"); end
                1: begin bus_write({9'h100, lo}, d); m_dir = d; check_pins("R4 random dir"); end
                2, 3: begin bus_read(data_addr(msk, lo), rd); check("R3 R5 R6 random read", rd, exp_read(msk)); end
                4: set_pins(d);
                default: begin
                    bus_write({1'b1, (msk == 8'h00) ? 8'h01 : msk, lo}, d);
                    bus_read(data_addr(8'hFF, 2'b00), rd); check("R9 random outside", rd, exp_read(8'hFF));
                end
            endcase
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule